// File: doc/BRIEF.md
# Serial Divider Configuration Slave

This block is a write-only two-wire serial slave that holds the programming word of a frequency synthesizer: the 9-bit loop divider value, the 2-bit output divider select, two spread direction flags and a 6-bit spread depth. The serial clock and data lines are brought into the system clock domain through synchronizers. Edge detectors in that domain find START, STOP and the clock edges. The data line is driven only as an open-drain pull-down enable. Every transfer has a fixed shape. The address byte comes first, then one filler byte whose content is discarded, then three payload bytes. The payload is staged and reaches the outputs only when the master ends the transfer with STOP.

A strap-load pin gives a parallel path as well. While the pin is low, the divider outputs track the strap pins, spread is held off and serial commits are dropped. When the pin rises, the last strap values stay in place until the pin goes low again or a serial commit arrives. There is no streaming data path. Every pin is a plain level or strobe with no back-pressure: the master paces the bus, and the slave never stretches the clock.

Top module: `synth_cfg_i2c`

## Requirements
- R1: The slave answers only the 7-bit address 1101100 when addr_sel is 0, or 1101110 when addr_sel is 1, and only with the direction bit (LSB of the address byte) at 0 for a write. Any other address byte gets no acknowledge, and the rest of that transfer is ignored.
- R2: For an accepted address byte and for each of the next four bytes, sda_oe is asserted through the ninth SCL high phase. It is asserted only while the synchronized SCL is low.
- R3: Bytes after the fourth data byte get no acknowledge: sda_oe stays low. Their bits never reach the outputs.
- R4: Payload mapping, MSB first on the wire. Byte A is {n_sel[1:0], m_div[8:3]}. Byte B is {five ignored bits, m_div[2:0]}. Byte C is {spread_up, spread_dn, spread_amt[5:0]}.
- R5: The payload reaches the outputs only on STOP after all four data bytes, and within 12 clock cycles of the SDA rise at the pins.
- R6: A transfer ended by STOP, or cut by a new START, before the fourth data byte commits nothing. A new START restarts the byte count.
- R7: While strap_load_n is low, m_div and n_sel follow strap_m and strap_n within two clock cycles. After strap_load_n rises, they hold those values regardless of later strap pin changes.
- R8: While strap_load_n is low, spread_up and spread_dn read 0 and serial commits are discarded. With the pin high, a serial commit takes effect.
- R9: After reset, m_div = 256, n_sel = 0, spread_up = spread_dn = 0 and spread_amt = 0.
- R10: The filler byte is acknowledged, but its value has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Resolved serial data line, asynchronous |
| sda_oe | output | 1 | 1 = pull the data line low |
| addr_sel | input | 1 | Selects which of the two slave addresses is decoded |
| strap_load_n | input | 1 | Low = outputs track the strap pins; rising edge latches them |
| strap_m | input | 9 | Parallel loop divider value |
| strap_n | input | 2 | Parallel output divider select |
| m_div | output | 9 | Active loop divider value |
| n_sel | output | 2 | Active output divider select |
| spread_up | output | 1 | Upward spread flag |
| spread_dn | output | 1 | Downward spread flag |
| spread_amt | output | 6 | Spread depth |

## Verification
Some properties are checked on every cycle by the assertions. The acknowledge enable only rises while SCL is low, is never raised past the fourth data byte, and is silent outside a transfer. A commit pulse appears only once a full payload has been staged. Strap mode keeps spread off, follows the strap pins, and otherwise holds the outputs unless a commit arrives. Other behaviours only the bench scenarios can show, because they depend on what the master puts on the bus: address decoding for both select levels, the bit placement of each payload field, extra bytes leaving no trace, commits dropped after an early STOP or a repeated START, and serial writes ignored while the strap pin is low.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int M_W  = 9;
  localparam int N_W  = 2;
  localparam int SS_W = 6;

  typedef struct packed {
    logic [M_W-1:0]  m;
    logic [N_W-1:0]  n;
    logic            up;
    logic            dn;
    logic [SS_W-1:0] ss;
  } syn_cfg_t;

  localparam syn_cfg_t CFG_RESET = '{m: 9'd256, n: 2'd0, up: 1'b0, dn: 1'b0, ss: 6'd0};
endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[i] <= '1;
        else if (i == 0) st[i] <= d;
        else st[i] <= st[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/cs_i2c_rx.sv
module cs_i2c_rx #(
  parameter int         PAYLOAD   = 3,
  parameter logic [6:0] ADDR_BASE = 7'h6C,
  parameter logic [6:0] ADDR_ALT  = 7'h6E
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_s,
  input  logic                 sda_s,
  input  logic                 addr_sel,
  output logic                 sda_oe,
  output logic                 commit,
  output logic [PAYLOAD*8-1:0] stage_o
);
  localparam int DATA_BYTES = PAYLOAD + 1;
  localparam int IDX_W      = $clog2(DATA_BYTES + 4);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic scl_q, sda_q;
  logic active, skip, got_all;
  logic [3:0] bit_cnt;
  logic [IDX_W-1:0] byte_idx;
  logic [7:0] shreg;
  logic [PAYLOAD-1:0][7:0] stg;

  wire start_ev = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire [6:0] my_addr = addr_sel ? ADDR_ALT : ADDR_BASE;
  wire addr_ok = (shreg[7:1] == my_addr) && !shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1; sda_q <= 1'b1;
      active <= 1'b0; skip <= 1'b0; got_all <= 1'b0;
      bit_cnt <= '0; byte_idx <= '0; shreg <= '0; stg <= '0;
      sda_oe <= 1'b0; commit <= 1'b0;
    end else begin
      scl_q  <= scl_s;
      sda_q  <= sda_s;
      commit <= 1'b0;
      if (start_ev) begin
        active <= 1'b1; skip <= 1'b0; got_all <= 1'b0;
        bit_cnt <= '0; byte_idx <= '0; sda_oe <= 1'b0;
      end else if (stop_ev) begin
        commit  <= active & got_all & ~skip;
        active  <= 1'b0; got_all <= 1'b0; sda_oe <= 1'b0;
      end else if (active && !skip) begin
        if (scl_rise) begin
          if (bit_cnt == 4'd8) begin
            bit_cnt <= '0;
            if (byte_idx != IDX_MAX) byte_idx <= byte_idx + 1'b1;
          end else begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end
        end else if (scl_fall) begin
          if (bit_cnt == 4'd8) begin
            if (byte_idx == '0) begin
              if (addr_ok) sda_oe <= 1'b1;
              else skip <= 1'b1;
            end else if (byte_idx <= IDX_W'(DATA_BYTES)) begin
              sda_oe <= 1'b1;
              for (int k = 0; k < PAYLOAD; k++)
                if (byte_idx == IDX_W'(k + 2)) stg[k] <= shreg;
              if (byte_idx == IDX_W'(DATA_BYTES)) got_all <= 1'b1;
            end
          end else if (bit_cnt == 4'd0) begin
            sda_oe <= 1'b0;
          end
        end
      end
    end
  end

  assign stage_o = stg;

  p_oe_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  p_no_ack_extra_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> byte_idx <= IDX_W'(DATA_BYTES));
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sda_oe);
  p_commit_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !active && $past(got_all));
endmodule

// File: rtl/cs_cfg_regs.sv
module cs_cfg_regs
  import synth_cfg_pkg::*;
#(
  parameter int PAYLOAD = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pl_n,
  input  logic [M_W-1:0]       strap_m,
  input  logic [N_W-1:0]       strap_n,
  input  logic                 commit,
  input  logic [PAYLOAD*8-1:0] stage,
  output syn_cfg_t             cfg
);
  logic pl_q;
  wire [7:0] byte_a = stage[7:0];
  wire [7:0] byte_b = stage[15:8];
  wire [7:0] byte_c = stage[23:16];
  logic unused_bits;
  assign unused_bits = ^byte_b[7:3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg  <= CFG_RESET;
      pl_q <= 1'b1;
    end else begin
      pl_q <= pl_n;
      if (!pl_q) begin
        cfg.m  <= strap_m;
        cfg.n  <= strap_n;
        cfg.up <= 1'b0;
        cfg.dn <= 1'b0;
      end else if (commit) begin
        cfg.m  <= {byte_a[5:0], byte_b[2:0]};
        cfg.n  <= byte_a[7:6];
        cfg.up <= byte_c[7];
        cfg.dn <= byte_c[6];
        cfg.ss <= byte_c[5:0];
      end
    end
  end

  p_spread_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pl_q |=> !cfg.up && !cfg.dn);
  p_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pl_q |=> cfg.m == $past(strap_m) && cfg.n == $past(strap_n));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_q && !commit) |=> $stable(cfg));
endmodule

// File: rtl/synth_cfg_i2c.sv
module synth_cfg_i2c
  import synth_cfg_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         PAYLOAD     = 3,
  parameter logic [6:0] ADDR_BASE   = 7'h6C,
  parameter logic [6:0] ADDR_ALT    = 7'h6E
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe,
  input  logic            addr_sel,
  input  logic            strap_load_n,
  input  logic [M_W-1:0]  strap_m,
  input  logic [N_W-1:0]  strap_n,
  output logic [M_W-1:0]  m_div,
  output logic [N_W-1:0]  n_sel,
  output logic            spread_up,
  output logic            spread_dn,
  output logic [SS_W-1:0] spread_amt
);
  logic [1:0] bus_s;
  logic commit;
  logic [PAYLOAD*8-1:0] stage;
  syn_cfg_t cfg;

  cs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(bus_s));

  cs_i2c_rx #(.PAYLOAD(PAYLOAD), .ADDR_BASE(ADDR_BASE), .ADDR_ALT(ADDR_ALT)) u_rx (
    .clk(clk), .rst_n(rst_n), .scl_s(bus_s[1]), .sda_s(bus_s[0]),
    .addr_sel(addr_sel), .sda_oe(sda_oe), .commit(commit), .stage_o(stage));

  cs_cfg_regs #(.PAYLOAD(PAYLOAD)) u_cfg (
    .clk(clk), .rst_n(rst_n), .pl_n(strap_load_n), .strap_m(strap_m),
    .strap_n(strap_n), .commit(commit), .stage(stage), .cfg(cfg));

  assign m_div      = cfg.m;
  assign n_sel      = cfg.n;
  assign spread_up  = cfg.up;
  assign spread_dn  = cfg.dn;
  assign spread_amt = cfg.ss;
endmodule

// File: tb/synth_cfg_i2c_tb.sv
module synth_cfg_i2c_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       addr_sel = 1'b0, strap_load_n = 1'b1;
  logic [8:0] strap_m = '0;
  logic [1:0] strap_n = '0;
  logic       sda_oe, spread_up, spread_dn;
  logic [8:0] m_div;
  logic [1:0] n_sel;
  logic [5:0] spread_amt;
  wire        sda_line = sda_m & ~sda_oe;

  synth_cfg_i2c u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .strap_load_n(strap_load_n), .strap_m(strap_m),
    .strap_n(strap_n), .m_div(m_div), .n_sel(n_sel), .spread_up(spread_up),
    .spread_dn(spread_dn), .spread_amt(spread_amt));

  int n_chk = 0, n_fail = 0, cyc = 0, settle_until = 0;
  int exp_m = 256, exp_n = 0, exp_up = 0, exp_dn = 0, exp_ss = 0;
  bit ack;

  always @(posedge clk) cyc <= cyc + 1;

  // Reference model compared every clock (R4 R5 R7 R8 mapping and timing)
  always @(negedge clk) begin
    if (rst_n && cyc >= settle_until) begin
      n_chk++;
      if (int'(m_div) != exp_m || int'(n_sel) != exp_n || int'(spread_up) != exp_up ||
          int'(spread_dn) != exp_dn || int'(spread_amt) != exp_ss) begin
        n_fail++;
        $display("FAIL model R4/R5/R7/R8 at cycle %0d: actual m=%0d n=%0d up=%0d dn=%0d ss=%0d expected m=%0d n=%0d up=%0d dn=%0d ss=%0d",
                 cyc, m_div, n_sel, spread_up, spread_dn, spread_amt, exp_m, exp_n, exp_up, exp_dn, exp_ss);
      end
    end
  end

  always @(negedge clk) begin
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic i2c_start();
    scl_m = 0; tick(4); sda_m = 1; tick(4); scl_m = 1; tick(4);
    sda_m = 0; tick(4); scl_m = 0; tick(4);
  endtask

  task automatic i2c_stop();
    scl_m = 0; tick(4); sda_m = 0; tick(4); scl_m = 1; tick(4);
    sda_m = 1; settle_until = cyc + 12; tick(8);
  endtask

  task automatic send(input logic [7:0] b, input int exp_ack, input string req);
    for (int i = 7; i >= 0; i--) begin
      scl_m = 0; tick(4); sda_m = b[i]; tick(4); scl_m = 1; tick(8);
    end
    scl_m = 0; tick(4); sda_m = 1; tick(4); scl_m = 1; tick(4);
    ack = !sda_line;
    check(req, int'(ack), exp_ack);
    tick(4);
  endtask

  task automatic full_write(input logic [7:0] a, input logic [7:0] f,
                            input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    i2c_start();
    send(a, 1, "R1 address ack");
    send(f, 1, "R10 filler ack");
    send(b0, 1, "R2 data ack");
    send(b1, 1, "R2 data ack");
    send(b2, 1, "R2 data ack");
  endtask

  task automatic model_commit(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    if (strap_load_n) begin
      exp_m = int'({b0[5:0], b1[2:0]}); exp_n = int'(b0[7:6]);
      exp_up = int'(b2[7]); exp_dn = int'(b2[6]); exp_ss = int'(b2[5:0]);
    end
  endtask

  initial begin
    tick(5); rst_n = 1; tick(3);
    check("R9 reset m", int'(m_div), 256);
    check("R9 reset n", int'(n_sel), 0);
    check("R9 reset spread", int'({spread_up, spread_dn, spread_amt}), 0);

    // S1: base address, M=419 N=1 up dn ss=21, ignored upper bits in byte B
    full_write(8'hD8, 8'hA5, 8'h74, 8'hFB, 8'hD5);
    i2c_stop(); model_commit(8'h74, 8'hFB, 8'hD5); tick(4);
    check("R4 m field", int'(m_div), 419);
    check("R4 n field", int'(n_sel), 1);
    check("R5 spread committed", int'({spread_up, spread_dn, spread_amt}), {2'b11, 6'd21});
    check("R10 filler no effect", int'(spread_amt), 21);

    // S2: alternate address while base selected -> ignored
    i2c_start();
    send(8'hDC, 0, "R1 wrong address nack");
    send(8'h00, 0, "R1 rest ignored");
    i2c_stop(); tick(4);
    check("R1 no change", int'(m_div), 419);

    // S3: alternate address selected, extra bytes refused
    addr_sel = 1; tick(2);
    full_write(8'hDC, 8'h00, 8'hA5, 8'h04, 8'h4A);
    send(8'hFF, 0, "R3 extra byte nack");
    send(8'h00, 0, "R3 second extra nack");
    i2c_stop(); model_commit(8'hA5, 8'h04, 8'h4A); tick(4);
    check("R3 extra not stored ss", int'(spread_amt), 10);
    check("R4 m alt", int'(m_div), 300);
    check("R4 n alt", int'(n_sel), 2);

    // S4: STOP after two data bytes commits nothing
    i2c_start();
    send(8'hDC, 1, "R1 ack"); send(8'h00, 1, "R10 filler");
    send(8'h00, 1, "R2 ack"); send(8'h00, 1, "R2 ack");
    i2c_stop(); tick(4);
    check("R6 abort no commit", int'(m_div), 300);

    // S5: repeated START mid-transfer restarts count
    i2c_start();
    send(8'hDC, 1, "R1 ack"); send(8'h11, 1, "R10 filler"); send(8'hFF, 1, "R2 ack");
    full_write(8'hDC, 8'h22, 8'hD0, 8'h00, 8'h83);
    i2c_stop(); model_commit(8'hD0, 8'h00, 8'h83); tick(4);
    check("R6 restart m", int'(m_div), 128);
    check("R6 restart n", int'(n_sel), 3);

    // S6: read direction refused
    i2c_start(); send(8'hDD, 0, "R1 read nack"); i2c_stop(); tick(4);
    check("R1 read no change", int'(m_div), 128);

    // S7: strap mode
    strap_m = 9'd150; strap_n = 2'd3; strap_load_n = 0;
    settle_until = cyc + 6; exp_m = 150; exp_n = 3; exp_up = 0; exp_dn = 0;
    tick(8);
    check("R7 follow m", int'(m_div), 150);
    check("R8 spread off", int'({spread_up, spread_dn}), 0);
    strap_m = 9'd200; settle_until = cyc + 4; exp_m = 200; tick(6);
    check("R7 follow change", int'(m_div), 200);
    full_write(8'hDC, 8'h00, 8'h74, 8'h03, 8'hC1);
    i2c_stop(); tick(4);
    check("R8 serial ignored", int'(m_div), 200);
    check("R8 spread still off", int'({spread_up, spread_dn}), 0);
    strap_load_n = 1; settle_until = cyc + 4; tick(6);
    strap_m = 9'd77; strap_n = 2'd0; tick(8);
    check("R7 hold m", int'(m_div), 200);
    check("R7 hold n", int'(n_sel), 3);
    full_write(8'hDC, 8'h00, 8'hA5, 8'h04, 8'h4A);
    i2c_stop(); model_commit(8'hA5, 8'h04, 8'h4A); tick(4);
    check("R8 serial active", int'(m_div), 300);
    check("R8 spread dn", int'(spread_dn), 1);

    tick(10);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule